// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. It runs two predictors side by side. The first keys a table of 2-bit saturating counters on a shift register of recent branch outcomes. The second uses the low branch-address bits to pick a per-branch history, and that history then selects a 3-bit saturating counter. A third table of 2-bit counters, keyed by the same outcome history as the first predictor, decides which of the two predictions to pass on.

A lookup is purely combinational. The front end presents a branch address and gets back the final prediction, both component predictions, and the two table indices it used. It keeps these with the branch. When the branch resolves, it hands them back together with the address and the real outcome, so that training writes the same entries that were read. A context-switch strobe clears every table and the outcome history in one cycle. Reset clears them in the same way.

Top module: `tourn_pred`

## Requirements
- R1: After reset or a cycle with `ctxSwitch` high, every 2-bit counter holds 1, every 3-bit counter holds 3, every local history and the global history hold 0. As a result every lookup returns `predTaken`, `predGlobal` and `predLocal` as 0, with `predGhist` and `predLhist` equal to 0.
- R2: A counter predicts taken when its most significant bit is 1. `predTaken` equals `predGlobal` when the chooser entry at the current global history has its MSB set, and equals `predLocal` otherwise.
- R3: The local history entry is selected by `lookPc[PC_LSB +: LPC_BITS]`. Its value is output on `predLhist` and indexes the 3-bit counter table. All other address bits have no effect.
- R4: On a resolve, the 2-bit global counter at `resGhist` steps one toward the outcome: up when taken, down when not taken, holding at 3 and at 0.
- R5: On a resolve, the 3-bit local counter at `resLhist` steps one toward the outcome, holding at 7 and at 0.
- R6: On a resolve where `resGlobal` differs from `resLocal`, the chooser entry at `resGhist` steps up (toward global) if `resGlobal` equals `resTaken`, and down otherwise, saturating at 3 and 0. When they agree, the entry is left unchanged.
- R7: On a resolve, the global history and the local history entry selected by `resPc` each shift left by one, taking the outcome into bit 0 and discarding the oldest bit.
- R8: When `ctxSwitch` and `resValid` are high in the same cycle, the clear wins and no training takes effect.
- R9: A cycle with `resValid` low changes no state, whatever values are on the other resolve inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all tables |
| ctxSwitch | input | 1 | Clear all tables and histories this cycle |
| lookPc | input | PC_BITS | Branch address to predict |
| predTaken | output | 1 | Final direction prediction |
| predGlobal | output | 1 | Global component prediction |
| predLocal | output | 1 | Local component prediction |
| predGhist | output | GH_BITS | Global history used for this lookup |
| predLhist | output | LH_BITS | Local history used for this lookup |
| resValid | input | 1 | A branch resolves this cycle |
| resPc | input | PC_BITS | Address of the resolving branch |
| resTaken | input | 1 | Actual outcome (1 = taken) |
| resGhist | input | GH_BITS | Global history captured at its lookup |
| resLhist | input | LH_BITS | Local history captured at its lookup |
| resGlobal | input | 1 | Global prediction captured at its lookup |
| resLocal | input | 1 | Local prediction captured at its lookup |

## Verification
The bench runs a small configuration and, after every resolve, sweeps every local-history slot through the lookup path, comparing against a table model kept in the bench. A branch that is always taken drives the counters into saturation and shows whether they hold there or wrap. An alternating branch makes the local and global component predictions disagree, which exercises the chooser. A long pseudo-random stream, with resolve indices sometimes unrelated to the current histories, shows whether training writes the supplied entries rather than the current ones. Idle cycles with junk on the resolve inputs, plain clears, and a clear that coincides with a resolve show that only the intended events change state.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // wipe every table and the global history
    logic train;    // apply one resolve to counters and histories
    logic chTrain;  // chooser entry moves this cycle
    logic chUp;     // chooser direction: 1 = toward global
  } tpStrobe_t;

endpackage

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic      rst,
  input  logic      ctxSwitch,
  input  logic      resValid,
  input  logic      resTaken,
  input  logic      resGlobal,
  input  logic      resLocal,
  output tpStrobe_t strb
);

  logic clearNow;
  logic disagree;

  assign clearNow = rst | ctxSwitch;
  assign disagree = resGlobal ^ resLocal;

  always_comb begin
    strb         = '0;
    strb.clear   = clearNow;
    strb.train   = resValid & ~clearNow;
    strb.chTrain = resValid & ~clearNow & disagree;
    strb.chUp    = (resGlobal == resTaken);
  end

endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_BITS  = 32,
  parameter int PC_LSB   = 2,
  parameter int GH_BITS  = 12,
  parameter int LPC_BITS = 10,
  parameter int LH_BITS  = 10,
  parameter int GC_BITS  = 2,
  parameter int LC_BITS  = 3,
  parameter int CH_BITS  = 2
) (
  input  logic               clk,
  input  tpStrobe_t          strb,
  input  logic [PC_BITS-1:0] lookPc,
  input  logic [PC_BITS-1:0] resPc,
  input  logic               resTaken,
  input  logic [GH_BITS-1:0] resGhist,
  input  logic [LH_BITS-1:0] resLhist,
  output logic [GH_BITS-1:0] ghistOut,
  output logic [LH_BITS-1:0] lhistOut,
  output logic               gPred,
  output logic               lPred,
  output logic               finalPred
);

  localparam int GDEPTH  = 1 << GH_BITS;
  localparam int LPDEPTH = 1 << LPC_BITS;
  localparam int LCDEPTH = 1 << LH_BITS;

  localparam logic [GC_BITS-1:0] GC_MAX  = '1;
  localparam logic [LC_BITS-1:0] LC_MAX  = '1;
  localparam logic [CH_BITS-1:0] CH_MAX  = '1;
  localparam logic [GC_BITS-1:0] GC_INIT = GC_BITS'((1 << (GC_BITS - 1)) - 1);
  localparam logic [LC_BITS-1:0] LC_INIT = LC_BITS'((1 << (LC_BITS - 1)) - 1);
  localparam logic [CH_BITS-1:0] CH_INIT = CH_BITS'((1 << (CH_BITS - 1)) - 1);

  // Tables
  logic [GC_BITS-1:0] globalCtr [GDEPTH];
  logic [CH_BITS-1:0] chooseCtr [GDEPTH];
  logic [LH_BITS-1:0] localHist [LPDEPTH];
  logic [LC_BITS-1:0] localCtr  [LCDEPTH];
  logic [GH_BITS-1:0] ghistReg;

  // Address bits outside the index slice are deliberately ignored
  logic unusedPcBits;
  assign unusedPcBits = ^{lookPc, resPc};

  // Lookup path
  logic [LPC_BITS-1:0] lookSlot;
  logic                chooseGlobal;

  assign lookSlot = lookPc[PC_LSB +: LPC_BITS];

  always_comb begin
    ghistOut     = ghistReg;
    lhistOut     = localHist[lookSlot];
    gPred        = globalCtr[ghistReg][GC_BITS-1];
    lPred        = localCtr[lhistOut][LC_BITS-1];
    chooseGlobal = chooseCtr[ghistReg][CH_BITS-1];
    finalPred    = chooseGlobal ? gPred : lPred;
  end

  // Training path: read-modify-write of the supplied entries
  logic [LPC_BITS-1:0] resSlot;
  logic [GC_BITS-1:0]  gCur, gNext;
  logic [LC_BITS-1:0]  lCur, lNext;
  logic [CH_BITS-1:0]  cCur, cNext;
  logic [LH_BITS-1:0]  hCur, hNext;

  assign resSlot = resPc[PC_LSB +: LPC_BITS];

  always_comb begin
    gCur = globalCtr[resGhist];
    lCur = localCtr[resLhist];
    cCur = chooseCtr[resGhist];
    hCur = localHist[resSlot];

    if (resTaken) gNext = (gCur == GC_MAX) ? gCur : gCur + 1'b1;
    else          gNext = (gCur == '0)     ? gCur : gCur - 1'b1;

    if (resTaken) lNext = (lCur == LC_MAX) ? lCur : lCur + 1'b1;
    else          lNext = (lCur == '0)     ? lCur : lCur - 1'b1;

    if (strb.chUp) cNext = (cCur == CH_MAX) ? cCur : cCur + 1'b1;
    else           cNext = (cCur == '0)     ? cCur : cCur - 1'b1;

    hNext = {hCur[LH_BITS-2:0], resTaken};
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      for (int i = 0; i < GDEPTH; i++) begin
        globalCtr[i] <= GC_INIT;
        chooseCtr[i] <= CH_INIT;
      end
      for (int i = 0; i < LPDEPTH; i++) localHist[i] <= '0;
      for (int i = 0; i < LCDEPTH; i++) localCtr[i]  <= LC_INIT;
      ghistReg <= '0;
    end else begin
      if (strb.train) begin
        globalCtr[resGhist] <= gNext;
        localCtr[resLhist]  <= lNext;
        localHist[resSlot]  <= hNext;
        ghistReg            <= {ghistReg[GH_BITS-2:0], resTaken};
      end
      if (strb.chTrain) chooseCtr[resGhist] <= cNext;
    end
  end

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tp_pkg::*;
#(
  parameter int PC_BITS  = 32,
  parameter int PC_LSB   = 2,
  parameter int GH_BITS  = 12,
  parameter int LPC_BITS = 10,
  parameter int LH_BITS  = 10,
  parameter int GC_BITS  = 2,
  parameter int LC_BITS  = 3,
  parameter int CH_BITS  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctxSwitch,
  input  logic [PC_BITS-1:0] lookPc,
  output logic               predTaken,
  output logic               predGlobal,
  output logic               predLocal,
  output logic [GH_BITS-1:0] predGhist,
  output logic [LH_BITS-1:0] predLhist,
  input  logic               resValid,
  input  logic [PC_BITS-1:0] resPc,
  input  logic               resTaken,
  input  logic [GH_BITS-1:0] resGhist,
  input  logic [LH_BITS-1:0] resLhist,
  input  logic               resGlobal,
  input  logic               resLocal
);

  tpStrobe_t strb;

  tp_ctrl u_ctrl (
    .rst       (rst),
    .ctxSwitch (ctxSwitch),
    .resValid  (resValid),
    .resTaken  (resTaken),
    .resGlobal (resGlobal),
    .resLocal  (resLocal),
    .strb      (strb)
  );

  tp_datapath #(
    .PC_BITS  (PC_BITS),
    .PC_LSB   (PC_LSB),
    .GH_BITS  (GH_BITS),
    .LPC_BITS (LPC_BITS),
    .LH_BITS  (LH_BITS),
    .GC_BITS  (GC_BITS),
    .LC_BITS  (LC_BITS),
    .CH_BITS  (CH_BITS)
  ) u_dp (
    .clk       (clk),
    .strb      (strb),
    .lookPc    (lookPc),
    .resPc     (resPc),
    .resTaken  (resTaken),
    .resGhist  (resGhist),
    .resLhist  (resLhist),
    .ghistOut  (predGhist),
    .lhistOut  (predLhist),
    .gPred     (predGlobal),
    .lPred     (predLocal),
    .finalPred (predTaken)
  );

endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
  parameter int GH_BITS = 12,
  parameter int LH_BITS = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               ctxSwitch,
  input logic               resValid,
  input logic               resTaken,
  input logic               predTaken,
  input logic               predGlobal,
  input logic               predLocal,
  input logic [GH_BITS-1:0] predGhist,
  input logic [LH_BITS-1:0] predLhist
);

  // R1
  ctx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctxSwitch |=> (predGhist == '0) && (predLhist == '0) &&
                  !predTaken && !predGlobal && !predLocal);

  // R2
  agree_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (predGlobal == predLocal) |-> (predTaken == predLocal));

  // R7
  ghist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && !ctxSwitch) |=>
      predGhist == {$past(predGhist[GH_BITS-2:0]), $past(resTaken)});

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!resValid && !ctxSwitch) |=> $stable(predGhist));

endmodule

bind tourn_pred tourn_pred_chk #(
  .GH_BITS (GH_BITS),
  .LH_BITS (LH_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctxSwitch  (ctxSwitch),
  .resValid   (resValid),
  .resTaken   (resTaken),
  .predTaken  (predTaken),
  .predGlobal (predGlobal),
  .predLocal  (predLocal),
  .predGhist  (predGhist),
  .predLhist  (predLhist)
);

// File: tb/tourn_pred_test.sv
`timescale 1ns/1ps
module tourn_pred_test;

  localparam int PCB = 8;
  localparam int LSB = 2;
  localparam int GH  = 3;
  localparam int LP  = 2;
  localparam int LH  = 2;
  localparam int GD  = 1 << GH;
  localparam int PD  = 1 << LP;
  localparam int LD  = 1 << LH;

  logic           clk = 0;
  logic           rst = 1;
  logic           ctxSwitch = 0;
  logic [PCB-1:0] lookPc = '0;
  logic           predTaken, predGlobal, predLocal;
  logic [GH-1:0]  predGhist;
  logic [LH-1:0]  predLhist;
  logic           resValid = 0;
  logic [PCB-1:0] resPc = '0;
  logic           resTaken = 0;
  logic [GH-1:0]  resGhist = '0;
  logic [LH-1:0]  resLhist = '0;
  logic           resGlobal = 0;
  logic           resLocal = 0;

  always #2 clk = ~clk;

  tourn_pred #(
    .PC_BITS(PCB), .PC_LSB(LSB), .GH_BITS(GH), .LPC_BITS(LP), .LH_BITS(LH),
    .GC_BITS(2), .LC_BITS(3), .CH_BITS(2)
  ) uut (
    .clk(clk), .rst(rst), .ctxSwitch(ctxSwitch), .lookPc(lookPc),
    .predTaken(predTaken), .predGlobal(predGlobal), .predLocal(predLocal),
    .predGhist(predGhist), .predLhist(predLhist),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken),
    .resGhist(resGhist), .resLhist(resLhist),
    .resGlobal(resGlobal), .resLocal(resLocal)
  );

  int errors = 0;
  int checks = 0;
  int mg[GD];
  int mc[GD];
  int ml[LD];
  int mh[PD];
  int mgh;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < GD; i++) begin mg[i] = 1; mc[i] = 1; end
    for (int i = 0; i < LD; i++) ml[i] = 3;
    for (int i = 0; i < PD; i++) mh[i] = 0;
    mgh = 0;
  endtask

  function automatic int sat(input int v, input bit up, input int mx);
    if (up) return (v == mx) ? v : v + 1;
    return (v == 0) ? v : v - 1;
  endfunction

  // Sweep every local slot; tag overrides all labels when non-empty
  task automatic sweep(input string over);
    for (int p = 0; p < PD; p++) begin
      int lh;
      bit gp, lp, cs;
      lookPc = PCB'((p << LSB) | ((p * 5) << (LSB + LP)) | (p & 3));
      #1;
      lh = mh[p];
      gp = (mg[mgh] >= 2);
      lp = (ml[lh] >= 4);
      cs = (mc[mgh] >= 2);
      chk(over == "" ? "R7 global history" : over, int'(predGhist), mgh);
      chk(over == "" ? "R3 local history"  : over, int'(predLhist), lh);
      chk(over == "" ? "R4 global pred"    : over, int'(predGlobal), int'(gp));
      chk(over == "" ? "R5 local pred"     : over, int'(predLocal), int'(lp));
      chk(over == "" ? "R2 final pred"     : over, int'(predTaken), int'(cs ? gp : lp));
    end
  endtask

  task automatic resolve(input int pc, input int gh, input int lh,
                         input bit gp, input bit lp, input bit tk, input bit cx);
    int slot;
    @(negedge clk);
    resValid  = 1;
    resPc     = PCB'(pc);
    resGhist  = GH'(gh);
    resLhist  = LH'(lh);
    resGlobal = gp;
    resLocal  = lp;
    resTaken  = tk;
    ctxSwitch = cx;
    @(negedge clk);
    resValid  = 0;
    ctxSwitch = 0;
    if (cx) begin
      modelClear();
    end else begin
      slot = (pc >> LSB) & (PD - 1);
      mg[gh] = sat(mg[gh], tk, 3);
      ml[lh] = sat(ml[lh], tk, 7);
      if (gp != lp) mc[gh] = sat(mc[gh], (gp == tk), 3);
      mh[slot] = ((mh[slot] << 1) | int'(tk)) & (LD - 1);
      mgh = ((mgh << 1) | int'(tk)) & (GD - 1);
    end
  endtask

  task automatic natural(input int pc, input bit tk);
    int slot, lh;
    slot = (pc >> LSB) & (PD - 1);
    lh = mh[slot];
    resolve(pc, mgh, lh, mg[mgh] >= 2, ml[lh] >= 4, tk, 0);
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rst = 0;
    sweep("R1 reset state");

    // R5 saturation: always taken at slot 0, then one not-taken
    for (int i = 0; i < 10; i++) begin natural(0, 1); sweep(""); end
    natural(0, 0); sweep("R5 saturation hold");

    // R6 alternating branch at slot 1 makes components disagree
    for (int i = 0; i < 16; i++) begin natural(1 << LSB, i[0]); sweep(""); end

    // R4 R6 pseudo-random, sometimes with unrelated supplied indices
    for (int i = 0; i < 300; i++) begin
      int pc;
      bit tk;
      lfsr = step(lfsr);
      pc = int'(lfsr[7:0]);
      tk = lfsr[9] ^ lfsr[3];
      if (lfsr[12:11] == 2'b00)
        resolve(pc, int'(lfsr[15:13]), int'(lfsr[5:4]), lfsr[1], lfsr[14], tk, 0);
      else
        natural(pc, tk);
      sweep("");
    end

    // R9 idle cycles with junk on the resolve inputs
    @(negedge clk);
    resPc = 8'hFF; resTaken = 1; resGhist = '1; resLhist = '1;
    resGlobal = 1; resLocal = 0;
    repeat (5) @(negedge clk);
    sweep("R9 idle no change");

    // R1 clear alone, after training
    resolve(0, 0, 0, 0, 0, 0, 1);
    sweep("R1 context clear");

    // R8 clear wins over a simultaneous resolve
    for (int i = 0; i < 6; i++) natural(2 << LSB, 1);
    resolve(2 << LSB, mgh, mh[2], 1, 0, 1, 1);
    sweep("R8 clear precedence");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule